// File: doc/BRIEF.md
# PCI configuration address translator

This block turns a CPU access that lands in the downstream configuration window into a Type 0 PCI configuration address. The CPU side presents a 16-bit window offset, an access size in bytes and a read/write flag. A mapping register supplies the upper half of the 32-bit intermediate address, and bit 16 of that register selects between Type 0 forwarding and suppression. The device number is not carried as a binary field. It is the position of the lowest set bit in a one-hot select field taken from the upper part of the intermediate address.

A forwarded access leaves the block one clock later as a packed address with the enable bit set, along with its size and byte lane. Every forwarded access also clears the received master-abort and received target-abort flags of the bridge's status word. An access that cannot be forwarded is answered locally. Writes are discarded, and reads return all ones across the access width. An access with an empty select field raises a one-cycle error pulse and is then handled as suppressed. A static input provides the bus number.

Top module: `cfg_addr_xlate`

## Requirements
- R1: During and right after a synchronous reset, every output is zero: no forward, no suppression, no error, address, size, lane and read data all zero, and both status flags clear.
- R2: A request with a legal size, map bit 16 clear and a non-empty select field produces `cfg_valid_o` high for exactly one cycle, on the clock edge that samples the request. The address has bit 31 set, bits [30:24] zero, `bus_num_i` in [23:16], intermediate bits [10:8] in [10:8], intermediate bits [7:2] in [7:2], and [1:0] zero. The intermediate address is `{map_cfg_i[15:0], req_offset_i}`.
- R3: The device field [15:11] of the forwarded address is the index of the lowest set bit of intermediate bits [31:11]. Bit 11 maps to device 0 and bit 31 maps to device 20. Any higher set bits are ignored.
- R4: When map bit 16 is set, a legal-size request is not forwarded. `sup_o` pulses for one cycle, and `error_o` stays low.
- R5: On a suppressed read, `sup_rdata_o` has its low 8×size bits set to one and the bits above cleared. On a suppressed write, and in every cycle without a suppressed read, `sup_rdata_o` is zero.
- R6: With map bit 16 clear and intermediate bits [31:11] all zero, a legal-size request raises `error_o` for one cycle together with `sup_o`. The suppressed-read data of R5 follows, and nothing is forwarded.
- R7: `status_o[0]` (received master abort) is set by `mabort_set_i`, and `status_o[1]` (received target abort) is set by `tabort_set_i`. Both are cleared on the edge that forwards an access. When a set and a forward occur on the same edge, the set wins.
- R8: A request with size 0 or a size above 4 produces no forward, no suppression and no error, and it leaves the status flags unchanged.
- R9: While `cfg_valid_o` is high, `cfg_write_o`, `cfg_size_o` and `cfg_lane_o` carry the request's write flag, its size and its offset bits [1:0]. While `cfg_valid_o` is low, these outputs and `cfg_addr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | CPU access present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 3 | Access size in bytes; 1 to 4 are legal |
| req_offset_i | input | 16 | Offset within the configuration window |
| map_cfg_i | input | 32 | Mapping register: [15:0] upper address, [16] non-Type-0 |
| bus_num_i | input | 8 | Static bus number |
| mabort_set_i | input | 1 | Sets the received master-abort flag |
| tabort_set_i | input | 1 | Sets the received target-abort flag |
| cfg_valid_o | output | 1 | Forwarded configuration access, one cycle |
| cfg_write_o | output | 1 | Write flag of the forwarded access |
| cfg_addr_o | output | 32 | Packed configuration address with enable bit |
| cfg_size_o | output | 3 | Size of the forwarded access |
| cfg_lane_o | output | 2 | Starting byte lane of the forwarded access |
| sup_o | output | 1 | Access answered locally, one cycle |
| sup_rdata_o | output | 32 | Local read data for a suppressed read |
| error_o | output | 1 | Empty select field, one cycle |
| status_o | output | 2 | [0] master abort received, [1] target abort received |

## Verification
The select field is driven with a single bit at each end of its range, with bits coming from the offset and bits coming from the map register, and with several bits set together. These cases separate a correct lowest-bit search from an off-by-one, a highest-bit search and a wrong split between offset and map. Suppression is tried for reads of every legal width and for writes, which exposes mask-width errors and write-data leaks. Empty select fields are tried both with and without map bit 16, which shows the precedence between the suppression path and the error path. Illegal sizes, abort events that coincide with forwards, and back-to-back and random traffic are compared against the behavioural model on every clock.

// File: rtl/cfx_pkg.sv
package cfx_pkg;
  // Fixed field layout of a Type 0 configuration address.
  localparam int unsigned CFG_ADDR_W = 32;
  localparam int unsigned CFG_BUS_W  = 8;
  localparam int unsigned CFG_DEV_W  = 5;
  localparam int unsigned CFG_FUN_W  = 3;
  localparam int unsigned CFG_REG_W  = 6;
  localparam int unsigned DEV_LSB    = 11;
  localparam int unsigned FUN_LSB    = 8;
  localparam int unsigned REG_LSB    = 2;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_FWD  = 2'd1,
    DISP_SUP  = 2'd2,
    DISP_ERR  = 2'd3
  } disp_e;
endpackage

// File: rtl/cfx_onehot_lsb.sv
module cfx_onehot_lsb #(
  parameter int unsigned W     = 21,
  parameter int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // Scan from the top so the lowest set bit is the last to assign.
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/cfx_decode.sv
module cfx_decode
  import cfx_pkg::*;
#(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned TYPE_BIT  = 16,
  parameter int unsigned SIZE_W    = 3,
  parameter int unsigned MAX_BYTES = 4
) (
  input  logic                 valid_i,
  input  logic [SIZE_W-1:0]    size_i,
  input  logic [OFS_W-1:0]     offset_i,
  input  logic [CFG_ADDR_W-1:0] map_i,
  output disp_e                disp_o,
  output logic [CFG_DEV_W-1:0] dev_o,
  output logic [CFG_FUN_W-1:0] fun_o,
  output logic [CFG_REG_W-1:0] reg_o
);
  localparam int unsigned HI_W  = CFG_ADDR_W - OFS_W;
  localparam int unsigned SEL_W = CFG_ADDR_W - DEV_LSB;
  localparam int unsigned IDX_W = $clog2(SEL_W);

  logic [CFG_ADDR_W-1:0] inter;
  logic [SEL_W-1:0]      sel;
  logic [IDX_W-1:0]      sel_idx;
  logic                  sel_any;
  logic                  size_ok;

  assign inter = {map_i[HI_W-1:0], offset_i};
  assign sel   = inter[CFG_ADDR_W-1:DEV_LSB];

  cfx_onehot_lsb #(.W(SEL_W), .IDX_W(IDX_W)) u_lsb (
    .vec_i (sel),
    .idx_o (sel_idx),
    .any_o (sel_any)
  );

  assign size_ok = (size_i != '0) && (size_i <= SIZE_W'(MAX_BYTES));

  always_comb begin
    if (!valid_i || !size_ok)  disp_o = DISP_NONE;
    else if (map_i[TYPE_BIT])  disp_o = DISP_SUP;
    else if (!sel_any)         disp_o = DISP_ERR;
    else                       disp_o = DISP_FWD;
  end

  assign dev_o = CFG_DEV_W'(sel_idx);
  assign fun_o = inter[FUN_LSB +: CFG_FUN_W];
  assign reg_o = inter[REG_LSB +: CFG_REG_W];
endmodule

// File: rtl/cfx_rdmask.sv
module cfx_rdmask #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SIZE_W = 3
) (
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] mask_o
);
  localparam int unsigned NBYTES = DATA_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign mask_o[b*8 +: 8] = (size_i > SIZE_W'(b)) ? 8'hFF : 8'h00;
  end
endmodule

// File: rtl/cfx_status.sv
module cfx_status #(
  parameter int unsigned STAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_i,
  input  logic              clr_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q;

  for (genvar k = 0; k < STAT_W; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           stat_q[k] <= 1'b0;
      else if (set_i[k]) stat_q[k] <= 1'b1;
      else if (clr_i)    stat_q[k] <= 1'b0;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
  import cfx_pkg::*;
#(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned TYPE_BIT  = 16,
  parameter int unsigned MAX_BYTES = 4,
  parameter int unsigned SIZE_W    = 3,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [SIZE_W-1:0]     req_size_i,
  input  logic [OFS_W-1:0]      req_offset_i,
  input  logic [CFG_ADDR_W-1:0] map_cfg_i,
  input  logic [CFG_BUS_W-1:0]  bus_num_i,
  input  logic                  mabort_set_i,
  input  logic                  tabort_set_i,
  output logic                  cfg_valid_o,
  output logic                  cfg_write_o,
  output logic [CFG_ADDR_W-1:0] cfg_addr_o,
  output logic [SIZE_W-1:0]     cfg_size_o,
  output logic [1:0]            cfg_lane_o,
  output logic                  sup_o,
  output logic [DATA_W-1:0]     sup_rdata_o,
  output logic                  error_o,
  output logic [1:0]            status_o
);
  localparam int unsigned PAD_W = CFG_ADDR_W - 1 - CFG_BUS_W - CFG_DEV_W
                                  - CFG_FUN_W - CFG_REG_W - REG_LSB;

  disp_e                 disp;
  logic [CFG_DEV_W-1:0]  dev;
  logic [CFG_FUN_W-1:0]  fun;
  logic [CFG_REG_W-1:0]  regn;
  logic [DATA_W-1:0]     ones_mask;
  logic [CFG_ADDR_W-1:0] packed_addr;
  logic                  fwd, sup, err;

  cfx_decode #(
    .OFS_W(OFS_W), .TYPE_BIT(TYPE_BIT), .SIZE_W(SIZE_W), .MAX_BYTES(MAX_BYTES)
  ) u_dec (
    .valid_i  (req_valid_i),
    .size_i   (req_size_i),
    .offset_i (req_offset_i),
    .map_i    (map_cfg_i),
    .disp_o   (disp),
    .dev_o    (dev),
    .fun_o    (fun),
    .reg_o    (regn)
  );

  cfx_rdmask #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_mask (
    .size_i (req_size_i),
    .mask_o (ones_mask)
  );

  assign fwd = (disp == DISP_FWD);
  assign err = (disp == DISP_ERR);
  assign sup = (disp == DISP_SUP) || err;

  assign packed_addr = {1'b1, {PAD_W{1'b0}}, bus_num_i, dev, fun, regn,
                        {REG_LSB{1'b0}}};

  cfx_status #(.STAT_W(2)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .set_i  ({tabort_set_i, mabort_set_i}),
    .clr_i  (fwd),
    .stat_o (status_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_valid_o <= 1'b0;
      cfg_write_o <= 1'b0;
      cfg_addr_o  <= '0;
      cfg_size_o  <= '0;
      cfg_lane_o  <= '0;
      sup_o       <= 1'b0;
      sup_rdata_o <= '0;
      error_o     <= 1'b0;
    end else begin
      cfg_valid_o <= fwd;
      cfg_write_o <= fwd & req_write_i;
      cfg_addr_o  <= fwd ? packed_addr : '0;
      cfg_size_o  <= fwd ? req_size_i : '0;
      cfg_lane_o  <= fwd ? req_offset_i[1:0] : 2'b00;
      sup_o       <= sup;
      sup_rdata_o <= (sup && !req_write_i) ? ones_mask : '0;
      error_o     <= err;
    end
  end
endmodule

// File: rtl/cfx_checker.sv
module cfx_checker #(
  parameter int unsigned SEL_W = 21
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid_i,
  input logic        req_write_i,
  input logic [2:0]  req_size_i,
  input logic        mabort_set_i,
  input logic        tabort_set_i,
  input logic        cfg_valid_o,
  input logic [31:0] cfg_addr_o,
  input logic        sup_o,
  input logic [31:0] sup_rdata_o,
  input logic        error_o,
  input logic [1:0]  status_o
);
  a_r2_enable_bit: assert property (@(posedge clk) disable iff (rst)
    cfg_valid_o |-> (cfg_addr_o[31] && cfg_addr_o[30:24] == 7'd0 && cfg_addr_o[1:0] == 2'd0));

  a_r2_needs_request: assert property (@(posedge clk) disable iff (rst)
    cfg_valid_o |-> $past(req_valid_i));

  a_r3_dev_range: assert property (@(posedge clk) disable iff (rst)
    cfg_valid_o |-> (int'(cfg_addr_o[15:11]) < SEL_W));

  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cfg_valid_o && sup_o));

  a_r5_rdata_only_on_sup: assert property (@(posedge clk) disable iff (rst)
    (sup_rdata_o != 32'd0) |-> sup_o);

  a_r6_error_is_suppressed: assert property (@(posedge clk) disable iff (rst)
    error_o |-> (sup_o && !cfg_valid_o));

  a_r7_master_cleared: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid_o && !$past(mabort_set_i)) |-> !status_o[0]);

  a_r7_target_cleared: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid_o && !$past(tabort_set_i)) |-> !status_o[1]);

  a_r8_bad_size_silent: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && (req_size_i == 3'd0 || req_size_i > 3'd4)) |=>
      (!cfg_valid_o && !sup_o && !error_o));
endmodule

bind cfg_addr_xlate cfx_checker #(.SEL_W(21)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid_i  (req_valid_i),
  .req_write_i  (req_write_i),
  .req_size_i   (req_size_i),
  .mabort_set_i (mabort_set_i),
  .tabort_set_i (tabort_set_i),
  .cfg_valid_o  (cfg_valid_o),
  .cfg_addr_o   (cfg_addr_o),
  .sup_o        (sup_o),
  .sup_rdata_o  (sup_rdata_o),
  .error_o      (error_o),
  .status_o     (status_o)
);

// File: tb/cfg_addr_xlate_tb.sv
module cfg_addr_xlate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [2:0]  req_size_i = 3'd0;
  logic [15:0] req_offset_i = 16'd0;
  logic [31:0] map_cfg_i = 32'd0;
  logic [7:0]  bus_num_i = 8'h3A;
  logic        mabort_set_i = 1'b0;
  logic        tabort_set_i = 1'b0;
  logic        cfg_valid_o, cfg_write_o, sup_o, error_o;
  logic [31:0] cfg_addr_o, sup_rdata_o;
  logic [2:0]  cfg_size_o;
  logic [1:0]  cfg_lane_o, status_o;

  cfg_addr_xlate u_dut (.*);

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  // behavioural expectation, updated at every rising edge
  bit      e_valid, e_write, e_sup, e_err;
  int      e_addr, e_rdata;
  int      e_size, e_lane;
  bit      e_mab, e_tab;

  function automatic int ones_for(int sz);
    int m = 0;
    for (int b = 0; b < sz; b++) m = m | (32'hFF << (8 * b));
    return m;
  endfunction

  always @(posedge clk) begin
    bit fwd;
    fwd = 1'b0;
    e_valid = 0; e_write = 0; e_sup = 0; e_err = 0;
    e_addr = 0; e_rdata = 0; e_size = 0; e_lane = 0;
    if (rst) begin
      e_mab = 0; e_tab = 0;
    end else begin
      if (req_valid_i && req_size_i >= 1 && req_size_i <= 4) begin
        int full, sel, dev;
        full = {map_cfg_i[15:0], req_offset_i};
        sel = (full >> 11) & 32'h1F_FFFF;
        if (map_cfg_i[16]) begin
          e_sup = 1;
        end else if (sel == 0) begin
          e_sup = 1; e_err = 1;
        end else begin
          dev = 0;
          while (((sel >> dev) & 1) == 0) dev++;
          fwd = 1'b1;
          e_valid = 1; e_write = req_write_i;
          e_size = int'(req_size_i); e_lane = int'(req_offset_i[1:0]);
          e_addr = 32'h8000_0000 | (int'(bus_num_i) << 16) | (dev << 11) | (full & 32'h7FC);
        end
        if (e_sup && !req_write_i) e_rdata = ones_for(int'(req_size_i));
      end
      e_mab = mabort_set_i ? 1'b1 : (fwd ? 1'b0 : e_mab);
      e_tab = tabort_set_i ? 1'b1 : (fwd ? 1'b0 : e_tab);
    end
    chk_en = 1'b1;
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every output on every falling edge
  always @(negedge clk) begin
    if (chk_en && !done) begin
      bit r;
      r = rst;
      chk(r ? "R1" : "R2", "cfg_valid", int'(cfg_valid_o), int'(e_valid));
      chk(r ? "R1" : "R3", "cfg_addr", cfg_addr_o, e_addr);
      chk(r ? "R1" : "R4", "sup", int'(sup_o), int'(e_sup));
      chk(r ? "R1" : "R5", "sup_rdata", sup_rdata_o, e_rdata);
      chk(r ? "R1" : "R6", "error", int'(error_o), int'(e_err));
      chk(r ? "R1" : "R7", "status", int'(status_o), int'({e_tab, e_mab}));
      chk(r ? "R1" : "R9", "write", int'(cfg_write_o), int'(e_write));
      chk(r ? "R1" : "R9", "size", int'(cfg_size_o), e_size);
      chk(r ? "R1" : "R9", "lane", int'(cfg_lane_o), e_lane);
    end
  end

  task automatic req(bit wr, int sz, int ofs, int map);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = wr;
    req_size_i = 3'(sz); req_offset_i = 16'(ofs); map_cfg_i = map;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2/R3: select bits at both ends, from the offset and from the map
    req(0, 4, 16'h0800 | 16'h0324, 32'h0);      // dev 0, fun 3, reg 0x09
    req(1, 2, 16'h8000 | 16'h07FD, 32'h0);      // dev 4, lane 1
    req(0, 1, 16'h0003, 32'h0000_0001);         // bit 16 -> dev 5
    req(0, 4, 16'h0000, 32'h0000_8000);         // bit 31 -> dev 20
    req(1, 3, 16'h5800, 32'h0000_F0F0);         // several bits: lowest wins (R3)
    // R4/R5: non-Type-0 reads of every width and a write
    for (int s = 1; s <= 4; s++) req(0, s, 16'h0800, 32'h0001_0000);
    req(1, 4, 16'h0800, 32'h0001_0000);
    // R6: empty select, read and write; bit 16 takes precedence over error
    req(0, 2, 16'h07FF, 32'h0);
    req(1, 4, 16'h0000, 32'h0);
    req(0, 3, 16'h0000, 32'h0001_0000);
    // R8: illegal sizes leave everything quiet
    @(negedge clk) mabort_set_i = 1'b1;
    @(negedge clk) mabort_set_i = 1'b0;
    req(0, 0, 16'h0800, 32'h0);
    req(1, 5, 16'h0800, 32'h0);
    req(0, 7, 16'h0800, 32'h0);
    chk("R8", "status after bad sizes", int'(status_o), 1);
    // R7: forward clears; set and forward on the same edge keep the flag
    req(0, 4, 16'h1000, 32'h0);
    chk("R7", "status cleared by forward", int'(status_o), 0);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_size_i = 3'd4;
    req_offset_i = 16'h1000; map_cfg_i = 32'h0; tabort_set_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0; tabort_set_i = 1'b0;
    chk("R7", "set wins over clear", int'(status_o), 2);
    // back-to-back and random traffic
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      req_valid_i  = ($urandom_range(0, 3) != 0);
      req_write_i  = 1'($urandom);
      req_size_i   = 3'($urandom);
      req_offset_i = 16'($urandom);
      map_cfg_i    = ($urandom_range(0, 3) == 0) ? 32'h0 : ($urandom & 32'h0001_FFFF);
      if ($urandom_range(0, 5) == 0) map_cfg_i[15:0] = 16'h0;
      if ($urandom_range(0, 5) == 0) req_offset_i[15:11] = 5'h0;
      mabort_set_i = ($urandom_range(0, 9) == 0);
      tabort_set_i = ($urandom_range(0, 9) == 0);
      bus_num_i    = (n == 200) ? 8'hC5 : bus_num_i;
    end
    @(negedge clk);
    req_valid_i = 1'b0; mabort_set_i = 1'b0; tabort_set_i = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset again mid-run returns everything to zero
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "status after reset", int'(status_o), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule